// File: doc/BRIEF.md
# OFDM Transmit Frame Assembler

This block turns four stored 64-sample time-domain OFDM symbols into one complete transmit frame. Before a frame is sent, each symbol is written sample by sample into a local memory through a write port. A slot index picks the symbol and an address picks the sample. A start pulse then makes the block stream 480 complex samples in a fixed order. The short training section comes first, then the long training section, then two payload symbols. Cyclic prefixes and repetitions are made on the fly by reading the memory at computed addresses, so each symbol is stored only once.

Each section has its own rule. The short training section sends the first 16 samples of its symbol ten times. The long training section sends a 32-sample prefix taken from the tail of its symbol, then the whole symbol twice. Each payload symbol sends a 16-sample prefix taken from its own tail, then the whole symbol once. The output uses a valid/ready handshake with start-of-frame and end-of-frame flags. A low ready pauses the stream with no loss of position.

Top module: `ofdm_frame_asm`

## Requirements
- R1: After reset, `out_valid`, `busy`, `out_sof` and `out_eof` are low.
- R2: Frame samples 0 to 159 come from slot 0, and sample k uses address k mod 16.
- R3: Frame samples 160 to 319 come from slot 1. The addresses are 32 to 63 first, then 0 to 63, then 0 to 63 again.
- R4: Frame samples 320 to 399 come from slot 2 and samples 400 to 479 come from slot 3. In each of these, the addresses are 48 to 63, then 0 to 63.
- R5: A frame is exactly 480 transferred samples. `out_valid` drops on the cycle after the 480th transfer.
- R6: `out_sof` is high on frame sample 0 only.
- R7: `out_eof` is high on frame sample 479 only.
- R8: A start pulse while `busy` is high is ignored. The running frame keeps its position and no second frame follows.
- R9: While `out_valid` is high and `out_ready` is low, the sample and both flags hold steady, and no sample is skipped.
- R10: The write port encodes slots as 0 = short training, 1 = long training, 2 = payload 1, 3 = payload 2. `wr_addr` is the sample index 0 to 63. Writes are accepted only while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Symbol memory write strobe |
| wr_slot | input | 2 | Symbol slot to write |
| wr_addr | input | 6 | Sample index within the symbol |
| wr_re | input | 16 | Real part of the written sample |
| wr_im | input | 16 | Imaginary part of the written sample |
| start | input | 1 | Frame start pulse |
| busy | output | 1 | High while a frame is in progress |
| out_ready | input | 1 | Downstream ready |
| out_valid | output | 1 | Output sample valid |
| out_re | output | 16 | Real part of the output sample |
| out_im | output | 16 | Imaginary part of the output sample |
| out_sof | output | 1 | First sample of the frame |
| out_eof | output | 1 | Last sample of the frame |

## Verification
The bench targets the section boundaries at samples 159/160, 191/192, 319/320 and 399/400. A design with a wrong prefix offset or a wrong repetition count would send the wrong address there, or take the sample from the neighbouring slot. It stalls the stream with a pseudo-random ready pattern: a design that advanced on valid alone would drop samples, and one that let data drift during a stall would fail the hold checks. It also pulses start and writes to a live slot in the middle of a frame. A design that restarted, or that let the write reach the memory, would change the frame length or corrupt the second payload symbol.

// File: rtl/ofdm_frame_asm.sv
module ofdm_frame_asm #(
  parameter int DW      = 16,
  parameter int FFT_N   = 64,
  parameter int STS_PER = 16,
  parameter int STS_REP = 10,
  parameter int LTS_CP  = 32,
  parameter int DATA_CP = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [1:0]               wr_slot,
  input  logic [$clog2(FFT_N)-1:0] wr_addr,
  input  logic [DW-1:0]            wr_re,
  input  logic [DW-1:0]            wr_im,
  input  logic                     start,
  output logic                     busy,
  input  logic                     out_ready,
  output logic                     out_valid,
  output logic [DW-1:0]            out_re,
  output logic [DW-1:0]            out_im,
  output logic                     out_sof,
  output logic                     out_eof
);

  localparam int AW       = $clog2(FFT_N);
  localparam int STS_LEN  = STS_PER * STS_REP;
  localparam int LTS_LEN  = LTS_CP + 2 * FFT_N;
  localparam int DATA_LEN = DATA_CP + FFT_N;
  localparam int LMAX1    = (STS_LEN > LTS_LEN) ? STS_LEN : LTS_LEN;
  localparam int LMAX     = (LMAX1 > DATA_LEN) ? LMAX1 : DATA_LEN;
  localparam int CW       = $clog2(LMAX + 1);

  typedef enum logic [1:0] {SEC_STS, SEC_LTS, SEC_PL1, SEC_PL2} sec_t;

  logic [2*DW-1:0] mem [4][FFT_N];
  sec_t            sec;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   sec_len;
  logic [AW-1:0]   rd_addr;
  logic            sec_last;

  always_ff @(posedge clk)
    if (wr_en && !busy) mem[wr_slot][wr_addr] <= {wr_re, wr_im};

  always_comb begin
    case (sec)
      SEC_STS: begin
        sec_len = CW'(STS_LEN);
        rd_addr = AW'(cnt % CW'(STS_PER));
      end
      SEC_LTS: begin
        sec_len = CW'(LTS_LEN);
        rd_addr = AW'(cnt + CW'(FFT_N - LTS_CP));
      end
      default: begin
        sec_len = CW'(DATA_LEN);
        rd_addr = AW'(cnt + CW'(FFT_N - DATA_CP));
      end
    endcase
  end

  assign sec_last  = (cnt == sec_len - 1'b1);
  assign out_valid = busy;
  assign {out_re, out_im} = mem[sec][rd_addr];
  assign out_sof   = busy && sec == SEC_STS && cnt == '0;
  assign out_eof   = busy && sec == SEC_PL2 && sec_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sec  <= SEC_STS;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        sec  <= SEC_STS;
        cnt  <= '0;
      end
    end else if (out_ready) begin
      if (sec_last) begin
        cnt <= '0;
        if (sec == SEC_PL2) busy <= 1'b0;
        else                sec  <= sec_t'(sec + 2'd1);
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_re) && $stable(out_im)
                                && $stable(out_sof) && $stable(out_eof));

  a_r5_end_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_eof |=> !out_valid);

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !out_sof |=> !out_sof);

  a_r6_sof_then_advance: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof && out_ready |=> out_valid && !out_sof);

  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_sof, out_eof}));

endmodule

// File: tb/tb_ofdm_frame_asm.sv
module tb_ofdm_frame_asm;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, start = 1'b0, out_ready = 1'b1;
  logic [1:0] wr_slot = '0;
  logic [5:0] wr_addr = '0;
  logic [15:0] wr_re = '0, wr_im = '0;
  logic busy, out_valid, out_sof, out_eof;
  logic [15:0] out_re, out_im;

  always #2.5 clk = ~clk;

  ofdm_frame_asm dut (.clk, .rst_n, .wr_en, .wr_slot, .wr_addr, .wr_re, .wr_im,
    .start, .busy, .out_ready, .out_valid, .out_re, .out_im, .out_sof, .out_eof);

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] cap [480];
  logic cap_sof [480], cap_eof [480];
  int ncap;

  localparam int TAB [14][3] = '{
    '{0,0,0}, '{17,0,1}, '{159,0,15}, '{160,1,32}, '{191,1,63}, '{192,1,0},
    '{255,1,63}, '{256,1,0}, '{319,1,63}, '{320,2,48}, '{336,2,0},
    '{399,2,63}, '{400,3,48}, '{479,3,63}};

  function automatic logic [31:0] pat(int slot, int addr);
    return {16'(slot * 1000 + addr + 7), 16'(16'hF000 ^ (slot << 8) ^ addr)};
  endfunction

  function automatic logic [31:0] model(int p);
    int q;
    if (p < 160) return pat(0, p % 16);
    if (p < 320) begin
      q = p - 160;
      return (q < 32) ? pat(1, 32 + q) : pat(1, (q - 32) % 64);
    end
    q = (p - 320) % 80;
    return pat(p < 400 ? 2 : 3, (q < 16) ? 48 + q : q - 16);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int slot, input int addr, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_slot = 2'(slot); wr_addr = 6'(addr); {wr_re, wr_im} = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_frame(input bit bp, input bit mid_start, input bit mid_write);
    logic [31:0] lfsr = 32'hACE1;
    bit stall = 1'b0;
    logic [33:0] held = '0;
    ncap = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int t = 0; t < 3000; t++) begin
      if (t > 0) @(negedge clk);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      out_ready = bp ? lfsr[0] | lfsr[3] : 1'b1;
      start = mid_start && ncap == 100;
      wr_en = mid_write && ncap == 200;
      wr_slot = 2'd3; wr_addr = 6'd5; {wr_re, wr_im} = 32'hDEAD_BEEF;
      #1;
      if (stall) chk({out_valid, out_re, out_im, out_sof, out_eof} == {1'b1, held},
                     "R9 hold", {out_re, out_im}, held[33:2]);
      stall = out_valid && !out_ready;
      held = {out_re, out_im, out_sof, out_eof};
      if (!out_valid) break;
      if (out_ready && ncap < 480) begin
        cap[ncap] = {out_re, out_im};
        cap_sof[ncap] = out_sof;
        cap_eof[ncap] = out_eof;
        ncap++;
      end
    end
    start = 1'b0; wr_en = 1'b0; out_ready = 1'b1;
  endtask

  task automatic check_frame(input string tag);
    int bad = 0;
    chk(ncap == 480, "R5 frame length", 32'(ncap), 32'd480);
    for (int p = 0; p < ncap; p++) begin
      string r = p < 160 ? "R2" : p < 320 ? "R3" : "R4";
      if (cap[p] != model(p) && bad < 4) begin
        bad++;
        chk(1'b0, {r, " sample ", tag}, cap[p], model(p));
      end
      if (cap_sof[p] != (p == 0)) chk(1'b0, "R6 sof", 32'(p), 32'd0);
      if (cap_eof[p] != (p == 479)) chk(1'b0, "R7 eof", 32'(p), 32'd479);
    end
    chk(bad == 0, {"R2 R3 R4 content ", tag}, 32'(bad), 32'd0);
    chk(ncap > 0 && cap_sof[0], "R6 sof first", 32'(ncap), 32'd1);
    chk(ncap == 480 && cap_eof[479], "R7 eof last", 32'(ncap), 32'd480);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual %0d expected below 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && !busy && !out_sof && !out_eof, "R1 reset",
        {28'd0, out_valid, busy, out_sof, out_eof}, 32'd0);
    rst_n = 1'b1;
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 64; a++) wr(s, a, pat(s, a));

    // R2 R3 R4 R5 R6 R7 plain frame, then table walk
    run_frame(1'b0, 1'b0, 1'b0);
    check_frame("plain");
    for (int i = 0; i < 14; i++)
      chk(cap[TAB[i][0]] == pat(TAB[i][1], TAB[i][2]),
          TAB[i][0] < 160 ? "R2 table" : TAB[i][0] < 320 ? "R3 table" : "R4 table",
          cap[TAB[i][0]], pat(TAB[i][1], TAB[i][2]));

    // R9 backpressure
    run_frame(1'b1, 1'b0, 1'b0);
    check_frame("stall");

    // R8 start during frame, R10 write during frame ignored
    run_frame(1'b0, 1'b1, 1'b1);
    check_frame("midstart");
    repeat (5) @(negedge clk);
    #1;
    chk(!out_valid && !busy, "R8 no second frame", {31'd0, busy}, 32'd0);

    // R10 write while idle takes effect
    wr(0, 0, 32'h1234_5678);
    run_frame(1'b0, 1'b0, 1'b0);
    chk(cap[0] == 32'h1234_5678, "R10 idle write slot0", cap[0], 32'h1234_5678);
    chk(cap[16] == 32'h1234_5678, "R2 repeat of new sample", cap[16], 32'h1234_5678);
    chk(cap[404] == pat(3, 52), "R10 slot3 intact", cap[404], pat(3, 52));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule